// File: doc/BRIEF.md
# Instruction Fetch and Operand Address Sequencer

This block is the front end of a 20-bit accumulator machine that uses 13-bit operand addresses. It runs a fixed series of register transfers, one per clock. It reads the next instruction word from memory and places it in the instruction register. It then forms the effective operand address: first, when selected, it adds the index register, and then, when selected, it fetches a pointer from memory. After that it gives control to an execute stage and waits until that stage reports completion.

A two-bit major state shows which part of the series is active. A phase counter counts the transfers made for the current instruction. The memory port is a simple read port, and memory must return the word for the presented address within the same cycle. The opcode field is passed through to the execute stage. If a read address falls outside the implemented memory, the block stops and raises an error that stays set until reset.

Top module: `iseq_top`

## Requirements
- R1: A synchronous active-high reset clears PC, AR, BR, IR, the phase counter and the error flag, and sets the major state to fetch (code 00).
- R2: Fetch uses three consecutive cycles. In phase 0, AR takes the value of PC. In phase 1, BR takes mem[AR] and PC increments by one, modulo 2^20. In phase 2, IR takes BR and AR takes BR[12:0] zero-extended.
- R3: The major state codes are 00 fetch, 01 indexed, 10 indirect and 11 execute. After fetch, the next state is indexed when word bit 13 is set. Otherwise it is indirect when bit 14 is set. Otherwise it is execute.
- R4: The indexed state takes one cycle and sets AR to IR[12:0] plus index_i, modulo 2^20. It then moves to indirect when IR bit 14 is set and to execute when that bit is clear.
- R5: The indirect state takes two cycles. In the first, BR takes mem[AR]. In the second, AR takes BR[12:0] zero-extended, and the state then becomes execute.
- R6: The phase counter advances by one after every transfer cycle in fetch, indexed and indirect. It holds its value while the block waits in execute, and it returns to 0 when an instruction completes.
- R7: In execute, exec_go is high and opcode_o equals IR[19:15]. The block stays in execute until exec_done is high, and then returns to fetch. exec_done has no effect in any other state.
- R8: mem_rd is high only in fetch phase 1 and in the first indirect cycle, and mem_addr always equals AR.
- R9: A read with AR at or above MEM_DEPTH sets err_o and leaves every register, the state and the phase unchanged. The block then stays frozen, with err_o high, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 20 | Read address (AR) |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 20 | Read data, valid in the cycle of the request |
| index_i | input | 20 | Index register value |
| exec_done | input | 1 | Execute stage has finished the instruction |
| exec_go | output | 1 | Execute stage owns the instruction |
| opcode_o | output | 5 | IR[19:15] |
| state_o | output | 2 | Major state |
| phase_o | output | 4 | Phase counter |
| pc_o | output | 20 | Program counter |
| ar_o | output | 20 | Address register |
| br_o | output | 20 | Buffer register |
| ir_o | output | 20 | Instruction register |
| err_o | output | 1 | Sticky out-of-range read error |

## Verification
The hardest path to reach from the ports is the one where an indexed sum either wraps past 2^20 or lands beyond the memory depth and is then followed by an indirect read. Both cases depend on the value of index_i in the single indexed cycle. The bench therefore sets index_i from the current program counter, so that each planned instruction meets its own index. The program contains an instruction whose sum wraps back into range and one whose sum lands out of range, and the second of these must trip the error and freeze the block. To check that exec_done is ignored outside execute, stray exec_done pulses are also driven in non-execute cycles.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

    typedef enum logic [1:0] {
        MS_FETCH = 2'b00,
        MS_INDEX = 2'b01,
        MS_INDIR = 2'b10,
        MS_EXEC  = 2'b11
    } major_t;

    typedef enum logic [2:0] {
        XF_IDLE,
        XF_AR_PC,
        XF_RD_FETCH,
        XF_LD_IR,
        XF_ADD_IDX,
        XF_RD_IND,
        XF_AR_BR
    } xfer_t;

    localparam int IDX_BIT = 13;
    localparam int IND_BIT = 14;

    typedef struct packed {
        logic indexed;
        logic indirect;
    } amode_t;

    function automatic major_t after_fetch(input amode_t m);
        if (m.indexed)       return MS_INDEX;
        else if (m.indirect) return MS_INDIR;
        else                 return MS_EXEC;
    endfunction

    function automatic major_t after_index(input amode_t m);
        return m.indirect ? MS_INDIR : MS_EXEC;
    endfunction

    function automatic logic is_read(input xfer_t x);
        return (x == XF_RD_FETCH) || (x == XF_RD_IND);
    endfunction

endpackage

// File: rtl/iseq_addr.sv
module iseq_addr #(
    parameter int DATA_W    = 20,
    parameter int MEM_DEPTH = 6144
) (
    input  logic [DATA_W-1:0] ar,
    output logic              rd_ok
);
    localparam logic [DATA_W:0] LIMIT = (DATA_W+1)'(MEM_DEPTH);

    always_comb rd_ok = ({1'b0, ar} < LIMIT);
endmodule

// File: rtl/iseq_ctrl.sv
module iseq_ctrl
    import iseq_pkg::*;
#(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exec_done,
    input  logic               rd_ok,
    input  amode_t             mode_br,
    input  amode_t             mode_ir,
    output major_t             state,
    output logic [PHASE_W-1:0] phase,
    output xfer_t              xfer,
    output logic               fault,
    output logic               err
);
    logic [1:0] step;

    always_comb begin
        xfer = XF_IDLE;
        if (!err) begin
            case (state)
                MS_FETCH: begin
                    if (step == 2'd0)      xfer = XF_AR_PC;
                    else if (step == 2'd1) xfer = XF_RD_FETCH;
                    else                   xfer = XF_LD_IR;
                end
                MS_INDEX: xfer = XF_ADD_IDX;
                MS_INDIR: xfer = (step == 2'd0) ? XF_RD_IND : XF_AR_BR;
                default:  xfer = XF_IDLE;
            endcase
        end
        fault = is_read(xfer) && !rd_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_FETCH;
            step  <= 2'd0;
            phase <= '0;
            err   <= 1'b0;
        end else if (!err) begin
            if (fault) begin
                err <= 1'b1;
            end else begin
                case (state)
                    MS_FETCH: begin
                        phase <= phase + 1'b1;
                        if (step == 2'd2) begin
                            step  <= 2'd0;
                            state <= after_fetch(mode_br);
                        end else begin
                            step <= step + 2'd1;
                        end
                    end
                    MS_INDEX: begin
                        phase <= phase + 1'b1;
                        step  <= 2'd0;
                        state <= after_index(mode_ir);
                    end
                    MS_INDIR: begin
                        phase <= phase + 1'b1;
                        if (step == 2'd0) begin
                            step <= 2'd1;
                        end else begin
                            step  <= 2'd0;
                            state <= MS_EXEC;
                        end
                    end
                    default: begin
                        if (exec_done) begin
                            state <= MS_FETCH;
                            step  <= 2'd0;
                            phase <= '0;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/iseq_regs.sv
module iseq_regs
    import iseq_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xfer,
    input  logic              fault,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] index_val,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] ar,
    output logic [DATA_W-1:0] br,
    output logic [DATA_W-1:0] ir
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] br_addr;
    logic [DATA_W-1:0] ir_addr;

    always_comb begin
        br_addr = {{PAD_W{1'b0}}, br[ADDR_W-1:0]};
        ir_addr = {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ar <= '0;
            br <= '0;
            ir <= '0;
        end else begin
            case (xfer)
                XF_AR_PC: ar <= pc;
                XF_RD_FETCH: begin
                    if (!fault) begin
                        br <= rdata;
                        pc <= pc + DATA_W'(1);
                    end
                end
                XF_LD_IR: begin
                    ir <= br;
                    ar <= br_addr;
                end
                XF_ADD_IDX: ar <= ir_addr + index_val;
                XF_RD_IND:  if (!fault) br <= rdata;
                XF_AR_BR:   ar <= br_addr;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/iseq_top.sv
module iseq_top
    import iseq_pkg::*;
#(
    parameter int DATA_W    = 20,
    parameter int ADDR_W    = 13,
    parameter int OPC_W     = 5,
    parameter int PHASE_W   = 4,
    parameter int MEM_DEPTH = 6144
) (
    input  logic               clk,
    input  logic               rst,
    output logic [DATA_W-1:0]  mem_addr,
    output logic               mem_rd,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [DATA_W-1:0]  index_i,
    input  logic               exec_done,
    output logic               exec_go,
    output logic [OPC_W-1:0]   opcode_o,
    output logic [1:0]         state_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic [DATA_W-1:0]  pc_o,
    output logic [DATA_W-1:0]  ar_o,
    output logic [DATA_W-1:0]  br_o,
    output logic [DATA_W-1:0]  ir_o,
    output logic               err_o
);
    major_t            state;
    xfer_t             xfer;
    logic              fault;
    logic              rd_ok;
    logic              err;
    logic [DATA_W-1:0] pc, ar, br, ir;
    amode_t            mode_br, mode_ir;

    always_comb begin
        mode_br = '{indexed: br[IDX_BIT], indirect: br[IND_BIT]};
        mode_ir = '{indexed: ir[IDX_BIT], indirect: ir[IND_BIT]};
    end

    iseq_addr #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_addr (
        .ar    (ar),
        .rd_ok (rd_ok)
    );

    iseq_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .exec_done (exec_done),
        .rd_ok     (rd_ok),
        .mode_br   (mode_br),
        .mode_ir   (mode_ir),
        .state     (state),
        .phase     (phase_o),
        .xfer      (xfer),
        .fault     (fault),
        .err       (err)
    );

    iseq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .xfer      (xfer),
        .fault     (fault),
        .rdata     (mem_rdata),
        .index_val (index_i),
        .pc        (pc),
        .ar        (ar),
        .br        (br),
        .ir        (ir)
    );

    always_comb begin
        mem_addr = ar;
        mem_rd   = is_read(xfer);
        exec_go  = (state == MS_EXEC) && !err;
        opcode_o = ir[DATA_W-1 -: OPC_W];
        state_o  = state;
        pc_o     = pc;
        ar_o     = ar;
        br_o     = br;
        ir_o     = ir;
        err_o    = err;
    end
endmodule

// File: rtl/iseq_chk.sv
module iseq_chk #(
    parameter int DATA_W  = 20,
    parameter int ADDR_W  = 13,
    parameter int PHASE_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         state,
    input logic [PHASE_W-1:0] phase,
    input logic [DATA_W-1:0]  pc,
    input logic [DATA_W-1:0]  ar,
    input logic [DATA_W-1:0]  br,
    input logic [DATA_W-1:0]  ir,
    input logic [DATA_W-1:0]  index_i,
    input logic               exec_done,
    input logic               mem_rd,
    input logic               err
);
    localparam logic [DATA_W-1:0] AMASK = DATA_W'((1 << ADDR_W) - 1);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (state == 2'b00 && phase == '0 && pc == '0 && !err));

    a_r2_ar_gets_pc: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00 && phase == '0 && !err) |=> (ar == $past(pc)));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00 && phase == PHASE_W'(1) && !err) |=>
        (err || pc == $past(pc) + DATA_W'(1)));

    a_r3_mode_select: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00 && phase == PHASE_W'(2) && !err) |=>
        (state == ($past(br[13]) ? 2'b01 : ($past(br[14]) ? 2'b10 : 2'b11))));

    a_r4_index_sum: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 && !err) |=>
        (ar == ($past(ir) & AMASK) + $past(index_i)));

    a_r7_exec_wait: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && !exec_done) |=> (state == 2'b11 && $stable(phase)));

    a_r6_phase_clear: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && exec_done && !err) |=> (state == 2'b00 && phase == '0));

    a_r8_read_only_fetch_or_indir: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (state == 2'b00 || state == 2'b10));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && $stable(pc) && $stable(ar) && $stable(br) && $stable(state)));
endmodule

bind iseq_top iseq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PHASE_W(PHASE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state_o),
    .phase     (phase_o),
    .pc        (pc_o),
    .ar        (ar_o),
    .br        (br_o),
    .ir        (ir_o),
    .index_i   (index_i),
    .exec_done (exec_done),
    .mem_rd    (mem_rd),
    .err       (err_o)
);

// File: tb/sim_iseq_top.sv
`timescale 1ns/1ps
module sim_iseq_top;
    localparam int DEPTH = 64;
    localparam int MASK  = 20'hFFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] mem_addr, mem_rdata, index_i, pc_o, ar_o, br_o, ir_o;
    logic        mem_rd, exec_done, exec_go, err_o;
    logic [4:0]  opcode_o;
    logic [1:0]  state_o;
    logic [3:0]  phase_o;

    logic [19:0] mem [0:DEPTH-1];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int exec_wait = 0;

    // behavioural reference state
    int m_state, m_step, m_phase, m_pc, m_ar, m_br, m_ir, m_err;

    always #2 clk = ~clk;

    iseq_top #(.MEM_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .index_i(index_i), .exec_done(exec_done),
        .exec_go(exec_go), .opcode_o(opcode_o), .state_o(state_o),
        .phase_o(phase_o), .pc_o(pc_o), .ar_o(ar_o), .br_o(br_o),
        .ir_o(ir_o), .err_o(err_o)
    );

    assign mem_rdata = (mem_addr < DEPTH) ? mem[mem_addr[5:0]] : 20'h0;

    function automatic logic [19:0] mk(input int opc, input int ind, input int idx, input int opd);
        return 20'((opc << 15) | (ind << 14) | (idx << 13) | (opd & 13'h1FFF));
    endfunction

    function automatic int mem_at(input int a);
        return (a < DEPTH) ? int'(mem[a]) : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_step = 0; m_phase = 0;
            m_pc = 0; m_ar = 0; m_br = 0; m_ir = 0; m_err = 0;
        end else if (m_err == 0) begin
            if (m_state == 0) begin
                if (m_step == 0) begin
                    m_ar = m_pc; m_step = 1; m_phase++;
                end else if (m_step == 1) begin
                    if (m_ar >= DEPTH) m_err = 1;
                    else begin
                        m_br = mem_at(m_ar); m_pc = (m_pc + 1) & MASK;
                        m_step = 2; m_phase++;
                    end
                end else begin
                    m_ir = m_br; m_ar = m_br & 'h1FFF; m_step = 0; m_phase++;
                    if (m_br[13]) m_state = 1;
                    else if (m_br[14]) m_state = 2;
                    else m_state = 3;
                end
            end else if (m_state == 1) begin
                m_ar = ((m_ir & 'h1FFF) + int'(index_i)) & MASK;
                m_phase++;
                m_state = m_ir[14] ? 2 : 3;
            end else if (m_state == 2) begin
                if (m_step == 0) begin
                    if (m_ar >= DEPTH) m_err = 1;
                    else begin m_br = mem_at(m_ar); m_step = 1; m_phase++; end
                end else begin
                    m_ar = m_br & 'h1FFF; m_step = 0; m_phase++; m_state = 3;
                end
            end else if (exec_done) begin
                m_state = 0; m_step = 0; m_phase = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        int exp_rd;
        exp_rd = (m_err == 0) && ((m_state == 0 && m_step == 1) || (m_state == 2 && m_step == 0));
        chk("R3", "state", int'(state_o), m_state);
        chk("R6", "phase", int'(phase_o), m_phase & 15);
        chk("R2", "pc", int'(pc_o), m_pc);
        chk("R4", "ar", int'(ar_o), m_ar);
        chk("R5", "br", int'(br_o), m_br);
        chk("R2", "ir", int'(ir_o), m_ir);
        chk("R7", "exec_go", int'(exec_go), (m_state == 3 && m_err == 0));
        chk("R7", "opcode", int'(opcode_o), (m_ir >> 15) & 31);
        chk("R8", "mem_rd", int'(mem_rd), exp_rd);
        chk("R8", "mem_addr", int'(mem_addr), m_ar);
        chk("R9", "err", int'(err_o), m_err);
    endtask

    task automatic drive_inputs();
        case (m_pc)
            2:       index_i = 20'd4;
            4:       index_i = 20'd30;
            6:       index_i = 20'hFFFF0;
            8:       index_i = 20'd10;
            default: index_i = 20'd0;
        endcase
        if (m_state == 3) begin
            exec_wait++;
            exec_done = (exec_wait > (cyc % 3));
        end else begin
            exec_wait = 0;
            exec_done = ((cyc % 5) == 2);  // stray pulse, must be ignored (R7)
        end
    endtask

    task automatic run_cycle();
        @(negedge clk);
        cyc++;
        compare_all();
        drive_inputs();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 20'h0;
        mem[0] = mk(1, 0, 0, 5);
        mem[1] = mk(2, 0, 1, 3);
        mem[2] = mk(3, 1, 0, 40);
        mem[3] = mk(4, 1, 1, 10);
        mem[4] = mk(31, 0, 0, 13'h1FFF);
        mem[5] = mk(5, 1, 1, 20);
        mem[6] = mk(6, 1, 0, 50);
        mem[7] = mk(7, 1, 1, 60);
        mem[40] = 20'hFE01A;
        mem[50] = 20'h01000;
        index_i = '0;
        exec_done = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "reset state", int'(state_o), 0);
        chk("R1", "reset phase", int'(phase_o), 0);
        chk("R1", "reset pc", int'(pc_o), 0);
        chk("R1", "reset err", int'(err_o), 0);
        rst = 1'b0;
        for (int k = 0; k < 400 && m_err == 0; k++) run_cycle();
        repeat (6) run_cycle();
        chk("R9", "error raised by out-of-range indirect read", int'(err_o), 1);
        chk("R9", "frozen pc", int'(pc_o), 8);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "reset after error state", int'(state_o), 0);
        chk("R1", "reset after error err", int'(err_o), 0);
        chk("R1", "reset after error pc", int'(pc_o), 0);
        rst = 1'b0;
        repeat (40) run_cycle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 5000);
        n_fail++;
        n_tests++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule